// File: doc/BRIEF.md
# On-Card DRAM and ROM Sequencer with Two-Level Refresh

This block sits between a fast 68000-style CPU bus and the memory on an accelerator card. Each bus cycle is sorted by its upper address bits into a DRAM access, a ROM access or an access to anything else, which is left to the I/O side of the card. DRAM reads and writes run a short row-then-column strobe sequence and are acknowledged with zero wait states. ROM reads get a chip select and an acknowledge one clock later. I/O cycles are neither selected nor acknowledged here.

Refresh is CAS-before-RAS, so the block keeps no refresh row counter. An external timer raises refresh requests at two levels. A normal request is held back until the CPU starts a ROM or I/O cycle. The refresh then runs on the idle DRAM while that slower cycle completes, so it never takes a slot from a DRAM access. If a normal request waits longer than a set number of clocks, it becomes urgent. An urgent request starts as soon as the DRAM sequencer is idle. A DRAM cycle that arrives in the meantime is stalled by holding back its acknowledge until refresh precharge has finished.

All strobe widths are whole clock counts held in parameters. They are chosen so that 60 ns DRAM timing is met with the CPU clock at either 20 MHz or 25 MHz.

Top module: `dram_ctl`

## Requirements
- R1: The upper address bits `cpu_tag` classify a cycle as DRAM when the value is below `RAM_TAGS` (default 4), as ROM when it equals `ROM_TAG` (default 4), and as I/O otherwise. With defaults, tag 0 is DRAM, 4 is ROM and 8 is I/O.
- R2: In a DRAM read, `dram_ras` and `cpu_ack` go high on the first clock edge that sees `cpu_as` high, with `dram_col_sel` low. On the next edge, `dram_cas` and `dram_col_sel` go high. All of these stay high while `cpu_as` is high and go low on the first edge that sees `cpu_as` low.
- R3: `dram_we` is high alongside RAS and CAS in a DRAM cycle with `cpu_rw` = 0 (write). It is low in reads and during refresh.
- R4: In a ROM cycle, `rom_sel` goes high on the first edge that sees `cpu_as` high and `cpu_ack` goes high one edge later. Both drop on the first edge that sees `cpu_as` low. A ROM cycle with no refresh pending drives no RAS or CAS.
- R5: An I/O cycle never raises `cpu_ack`, `rom_sel`, `dram_ras` or `dram_cas` when no refresh is pending.
- R6: A refresh raises `dram_cas` one clock before `dram_ras`, holds both for `REF_HOLD` clocks (default 2), drops both together, and then keeps RAS low for `PRE_CYC` clocks (default 1) before any new row strobe.
- R7: A normal refresh request does not start while the bus is idle or while DRAM cycles run. A DRAM cycle with a normal refresh pending is still served with zero wait states.
- R8: With a normal refresh pending, the edge that first sees `cpu_as` high for a ROM or I/O cycle starts the refresh (CAS high) alongside that cycle.
- R9: An urgent pulse on `ref_urgent` starts a refresh on the second edge after the pulse, even if a DRAM cycle is waiting. That DRAM cycle's RAS and acknowledge come on the first edge after refresh precharge ends.
- R10: A normal request left pending for `PROMOTE_CYC` clocks becomes urgent. On an idle bus, refresh CAS rises on edge `PROMOTE_CYC`+2 counted from the edge that captured the request.
- R11: Reset (`rst` high, synchronous) drives all outputs low and discards any pending refresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_as | input | 1 | Address strobe, high for the whole bus cycle |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_tag | input | TAG_W | Upper address bits used for region decode |
| ref_req | input | 1 | One-clock pulse: normal refresh request |
| ref_urgent | input | 1 | One-clock pulse: urgent refresh request |
| dram_ras | output | 1 | Row strobe, active high |
| dram_cas | output | 1 | Column strobe, active high |
| dram_we | output | 1 | DRAM write enable, active high |
| dram_col_sel | output | 1 | Address mux select, 1 = column address |
| rom_sel | output | 1 | ROM chip select, active high |
| cpu_ack | output | 1 | Data acknowledge to the CPU, active high |

## Verification
The bench targets the points where the two refresh levels meet bus traffic:
- A normal request that arrives just before a DRAM cycle must leave that cycle at zero wait states. A design that ran it at once would show CAS and a missing acknowledge instead.
- The same request must then start exactly on the edge that recognises a ROM cycle. A design keyed to the wrong event would refresh late or not at all.
- An urgent request racing a DRAM cycle must delay the acknowledge until precharge ends. An early acknowledge would let the CPU read while the DRAM is still in refresh.
- The promotion check counts edges to the exact cycle, which exposes an off-by-one in the age counter.
- A reset in the middle of a wait must clear the pending request, or a stray refresh would appear later.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  typedef enum logic [1:0] {
    REG_RAM,
    REG_ROM,
    REG_IO
  } region_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RAS,
    S_CAS,
    S_RCAS,
    S_RRAS,
    S_PRE
  } state_e;
endpackage

// File: rtl/dctl_decode.sv
module dctl_decode
  import dctl_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int RAM_TAGS = 4,
  parameter int ROM_TAG  = 4
) (
  input  logic [TAG_W-1:0] tag_i,
  output region_e          region_o
);
  always_comb begin
    if (tag_i < TAG_W'(RAM_TAGS))      region_o = REG_RAM;
    else if (tag_i == TAG_W'(ROM_TAG)) region_o = REG_ROM;
    else                               region_o = REG_IO;
  end
endmodule

// File: rtl/dctl_refresh_queue.sv
module dctl_refresh_queue #(
  parameter int PROMOTE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic urgent_i,
  input  logic start_i,
  output logic pend_o,
  output logic urg_o
);
  localparam int AW = $clog2(PROMOTE_CYC + 1);

  logic          pend_q, urg_q;
  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      urg_q  <= 1'b0;
      age_q  <= '0;
    end else begin
      if (start_i) begin
        pend_q <= 1'b0;
        urg_q  <= 1'b0;
        age_q  <= '0;
      end else if (pend_q && !urg_q) begin
        if (age_q == AW'(PROMOTE_CYC - 1)) urg_q <= 1'b1;
        else                               age_q <= age_q + 1'b1;
      end
      // new requests win over a same-cycle clear
      if (req_i || urgent_i) pend_q <= 1'b1;
      if (urgent_i)          urg_q  <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign urg_o  = urg_q;

  // R10: urgency only appears on top of a pending request or an urgent pulse
  assert_promote_from_pending_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(urg_q) |-> ($past(pend_q) || $past(urgent_i)));
endmodule

// File: rtl/dctl_sequencer.sv
module dctl_sequencer
  import dctl_pkg::*;
#(
  parameter int PRE_CYC  = 1,
  parameter int REF_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic as_i,
  input  logic rw_i,
  input  logic ram_hit_i,
  input  logic pend_i,
  input  logic urg_i,
  output logic ref_start_o,
  output logic ras_o,
  output logic cas_o,
  output logic mux_o,
  output logic we_o,
  output logic ack_o
);
  localparam int CMAX = (PRE_CYC > REF_HOLD) ? PRE_CYC : REF_HOLD;
  localparam int CW   = $clog2(CMAX + 1);

  state_e        st, st_n;
  logic [CW-1:0] cnt_q;
  logic          as_q, served_q;
  logic          ras_q, cas_q, mux_q, we_q, ack_q;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: begin
        if (urg_i)                                   st_n = S_RCAS;
        else if (as_i && ram_hit_i && !served_q)     st_n = S_RAS;
        else if (pend_i && as_i && !as_q && !ram_hit_i) st_n = S_RCAS;
      end
      S_RAS:  st_n = S_CAS;
      S_CAS:  if (!as_i) st_n = S_PRE;
      S_RCAS: st_n = S_RRAS;
      S_RRAS: if (cnt_q == '0) st_n = S_PRE;
      S_PRE:  if (cnt_q == '0) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  assign ref_start_o = (st == S_IDLE) && (st_n == S_RCAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt_q    <= '0;
      as_q     <= 1'b0;
      served_q <= 1'b0;
      ras_q    <= 1'b0;
      cas_q    <= 1'b0;
      mux_q    <= 1'b0;
      we_q     <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      st   <= st_n;
      as_q <= as_i;
      if (!as_i)            served_q <= 1'b0;
      else if (st == S_RAS) served_q <= 1'b1;

      if (st_n == S_RRAS && st != S_RRAS)     cnt_q <= CW'(REF_HOLD - 1);
      else if (st_n == S_PRE && st != S_PRE)  cnt_q <= CW'(PRE_CYC - 1);
      else if (cnt_q != '0)                   cnt_q <= cnt_q - 1'b1;

      ras_q <= (st_n == S_RAS) || (st_n == S_CAS) || (st_n == S_RRAS);
      cas_q <= (st_n == S_CAS) || (st_n == S_RCAS) || (st_n == S_RRAS);
      mux_q <= (st_n == S_CAS);
      ack_q <= (st_n == S_RAS) || ((st_n == S_CAS) && as_i);
      if (st_n == S_RAS)      we_q <= !rw_i;
      else if (st_n != S_CAS) we_q <= 1'b0;
    end
  end

  assign ras_o = ras_q;
  assign cas_o = cas_q;
  assign mux_o = mux_q;
  assign we_o  = we_q;
  assign ack_o = ack_q;

  // R6: in refresh, the row strobe only rises under an already asserted column strobe
  assert_cbr_order_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(ras_q) && cas_q) |-> $past(cas_q));

  // R2: an access column strobe follows the row strobe and selects the column address
  assert_col_after_row_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(cas_q) && ras_q) |-> ($past(ras_q) && mux_q));

  // R9: an urgent request seen while idle starts refresh on the next edge
  assert_urgent_first_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && urg_i) |=> (st == S_RCAS));
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dctl_pkg::*;
#(
  parameter int TAG_W       = 4,
  parameter int RAM_TAGS    = 4,
  parameter int ROM_TAG     = 4,
  parameter int PROMOTE_CYC = 200,
  parameter int PRE_CYC     = 1,
  parameter int REF_HOLD    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_as,
  input  logic             cpu_rw,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic             ref_req,
  input  logic             ref_urgent,
  output logic             dram_ras,
  output logic             dram_cas,
  output logic             dram_we,
  output logic             dram_col_sel,
  output logic             rom_sel,
  output logic             cpu_ack
);
  region_e region;
  logic    pend, urg, ref_start, ram_ack;
  logic    rom_sel_q, rom_ack_q;
  logic    io_hit;

  dctl_decode #(
    .TAG_W(TAG_W), .RAM_TAGS(RAM_TAGS), .ROM_TAG(ROM_TAG)
  ) u_decode (
    .tag_i(cpu_tag), .region_o(region)
  );

  dctl_refresh_queue #(
    .PROMOTE_CYC(PROMOTE_CYC)
  ) u_refq (
    .clk(clk), .rst(rst), .req_i(ref_req), .urgent_i(ref_urgent),
    .start_i(ref_start), .pend_o(pend), .urg_o(urg)
  );

  dctl_sequencer #(
    .PRE_CYC(PRE_CYC), .REF_HOLD(REF_HOLD)
  ) u_seq (
    .clk(clk), .rst(rst), .as_i(cpu_as), .rw_i(cpu_rw),
    .ram_hit_i(region == REG_RAM), .pend_i(pend), .urg_i(urg),
    .ref_start_o(ref_start), .ras_o(dram_ras), .cas_o(dram_cas),
    .mux_o(dram_col_sel), .we_o(dram_we), .ack_o(ram_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel_q <= 1'b0;
      rom_ack_q <= 1'b0;
    end else begin
      rom_sel_q <= cpu_as && (region == REG_ROM);
      rom_ack_q <= rom_sel_q && cpu_as && (region == REG_ROM);
    end
  end

  assign io_hit  = region == REG_IO;
  assign rom_sel = rom_sel_q;
  assign cpu_ack = ram_ack | rom_ack_q;

  // R5: a strobe held on an I/O address gets no acknowledge from this block
  assert_io_no_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_as && io_hit && $past(cpu_as && io_hit)) |-> !cpu_ack);

  // R4: the ROM acknowledge is never given without the ROM select one cycle earlier
  assert_rom_ack_after_sel_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_ack_q) |-> $past(rom_sel_q));
endmodule

// File: tb/test_dram_ctl.sv
module test_dram_ctl;
  localparam int PROMO = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       as_r = 1'b0, rw_r = 1'b1, req_r = 1'b0, urg_r = 1'b0;
  logic [3:0] tag_r = 4'h0;
  logic       ras, cas, we, colsel, romsel, ack;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_ctl #(
    .TAG_W(4), .RAM_TAGS(4), .ROM_TAG(4),
    .PROMOTE_CYC(PROMO), .PRE_CYC(1), .REF_HOLD(2)
  ) i_dram_ctl (
    .clk(clk), .rst(rst), .cpu_as(as_r), .cpu_rw(rw_r), .cpu_tag(tag_r),
    .ref_req(req_r), .ref_urgent(urg_r),
    .dram_ras(ras), .dram_cas(cas), .dram_we(we), .dram_col_sel(colsel),
    .rom_sel(romsel), .cpu_ack(ack)
  );

  // row: [23:20] requirement, [19] as, [18] rw, [17:14] tag, [13] req, [12] urgent,
  //      [11:6] expected {ras, cas, col_sel, we, rom_sel, ack}
  function automatic logic [23:0] row(int rid, bit a, bit rw, bit [3:0] tg, bit rq, bit ug,
                                      bit [5:0] exp);
    return {4'(rid), a, rw, tg, rq, ug, exp, 6'd0};
  endfunction

  localparam int NROWS = 38;
  localparam logic [23:0] VEC [0:NROWS-1] = '{
    // R1 R2: tag 0 is DRAM, read with zero wait states
    row(2, 1, 1, 4'h0, 0, 0, 6'b100001),
    row(2, 1, 1, 4'h0, 0, 0, 6'b111001),
    row(2, 0, 1, 4'h0, 0, 0, 6'b000000),
    row(2, 0, 1, 4'h0, 0, 0, 6'b000000),
    // R3: write, strobe held one extra clock
    row(3, 1, 0, 4'h0, 0, 0, 6'b100101),
    row(3, 1, 0, 4'h0, 0, 0, 6'b111101),
    row(3, 1, 0, 4'h0, 0, 0, 6'b111101),
    row(3, 0, 0, 4'h0, 0, 0, 6'b000000),
    row(3, 0, 0, 4'h0, 0, 0, 6'b000000),
    // R1 R4: tag 4 is ROM
    row(4, 1, 1, 4'h4, 0, 0, 6'b000010),
    row(4, 1, 1, 4'h4, 0, 0, 6'b000011),
    row(4, 0, 1, 4'h4, 0, 0, 6'b000000),
    // R1 R5: tag 8 is I/O
    row(5, 1, 1, 4'h8, 0, 0, 6'b000000),
    row(5, 1, 1, 4'h8, 0, 0, 6'b000000),
    row(5, 0, 1, 4'h8, 0, 0, 6'b000000),
    // R9: urgent pulse, then a DRAM read that must wait
    row(9, 0, 1, 4'h0, 0, 1, 6'b000000),
    row(9, 1, 1, 4'h0, 0, 0, 6'b010000),
    row(6, 1, 1, 4'h0, 0, 0, 6'b110000),  // R6 CAS before RAS
    row(6, 1, 1, 4'h0, 0, 0, 6'b110000),
    row(6, 1, 1, 4'h0, 0, 0, 6'b000000),
    row(9, 1, 1, 4'h0, 0, 0, 6'b000000),
    row(9, 1, 1, 4'h0, 0, 0, 6'b100001),
    row(2, 1, 1, 4'h0, 0, 0, 6'b111001),
    row(2, 0, 1, 4'h0, 0, 0, 6'b000000),
    row(2, 0, 1, 4'h0, 0, 0, 6'b000000),
    // R7: normal request is held back, DRAM still served at once
    row(7, 0, 1, 4'h0, 1, 0, 6'b000000),
    row(7, 0, 1, 4'h0, 0, 0, 6'b000000),
    row(7, 0, 1, 4'h0, 0, 0, 6'b000000),
    row(7, 0, 1, 4'h0, 0, 0, 6'b000000),
    row(7, 1, 1, 4'h0, 0, 0, 6'b100001),
    row(7, 1, 1, 4'h0, 0, 0, 6'b111001),
    row(7, 0, 1, 4'h0, 0, 0, 6'b000000),
    row(7, 0, 1, 4'h0, 0, 0, 6'b000000),
    // R8: refresh starts alongside the ROM cycle
    row(8, 1, 1, 4'h4, 0, 0, 6'b010010),
    row(8, 1, 1, 4'h4, 0, 0, 6'b110011),
    row(6, 1, 1, 4'h4, 0, 0, 6'b110011),
    row(6, 0, 1, 4'h4, 0, 0, 6'b000000),
    row(6, 0, 1, 4'h4, 0, 0, 6'b000000)
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (ras cas col we rom ack)", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] obs();
    return {ras, cas, colsel, we, romsel, ack};
  endfunction

  initial begin
    repeat (3) step();
    check("R11 outputs in reset", obs(), 6'b000000);
    rst = 1'b0;
    step();
    check("R11 idle after reset", obs(), 6'b000000);

    for (int i = 0; i < NROWS; i++) begin
      as_r  = VEC[i][19];
      rw_r  = VEC[i][18];
      tag_r = VEC[i][17:14];
      req_r = VEC[i][13];
      urg_r = VEC[i][12];
      step();
      check($sformatf("R%0d row %0d", VEC[i][23:20], i), obs(), VEC[i][11:6]);
    end
    as_r = 1'b0; req_r = 1'b0; urg_r = 1'b0;

    // R10: promotion of a normal request on an idle bus
    req_r = 1'b1;
    step();
    req_r = 1'b0;
    for (int k = 2; k <= PROMO + 1; k++) begin
      step();
      if (cas) check($sformatf("R10 early refresh at edge %0d", k), {5'd0, cas}, 6'd0);
    end
    n_run++;
    step();
    check("R10 refresh at promotion edge", obs(), 6'b010000);
    step();
    check("R10 RAS follows CAS", obs(), 6'b110000);
    repeat (4) step();
    check("R6 refresh finished", obs(), 6'b000000);

    // R11: reset discards a pending request
    req_r = 1'b1;
    step();
    req_r = 1'b0;
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < PROMO + 10; k++) begin
        step();
        if (cas || ras) seen = 1'b1;
      end
      check("R11 no refresh after reset", {5'd0, seen}, 6'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule